// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a general-purpose I/O port of 32 pins, reached through a simple 32-bit register bus. Each pin has a direction bit, an output latch and a synchronized input path. Toward the pad, each pin drives an output enable and an output value, and it receives an input level.

Software changes direction through two write-one registers. One register turns pins into outputs and the other turns them into inputs. Output values are written through two 16-pin registers. The upper half of each write is a per-pin enable, so any set of pins can be updated in a single bus write with no read-modify-write.

The output latch keeps its value while a pin is an input. A value can therefore be preloaded and then driven as soon as the pin becomes an output. Pad electrics, pin multiplexing and interrupts belong to other blocks.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 0, so all pins are inputs and `pinOe` is all zeros. Every output latch is 0, so `pinOut` is all zeros.
- R2: A write to byte address 0x04 clears the direction bit of each pin whose data bit is 1, turning that pin into an input. Pins whose data bit is 0 keep their direction.
- R3: A write to byte address 0x08 sets the direction bit of each pin whose data bit is 1, turning that pin into an output. Pins whose data bit is 0 keep their direction.
- R4: A read of address 0x08 returns the 32 direction bits, where 1 means output. `pinOe` equals these bits at all times.
- R5: A write to address 0x0C updates output latch k, for k from 0 to 15, to data bit k only where data bit k+16 is 1. The other latches keep their values.
- R6: A write to address 0x10 updates output latch 16+k to data bit k only where data bit k+16 is 1. The other latches keep their values.
- R7: A read of 0x0C returns latches 15..0 in bits 15:0. A read of 0x10 returns latches 31..16 in bits 15:0. In both cases bits 31:16 read as 0.
- R8: `pinOut` always equals the output latches, including while a pin is an input. A pin preloaded while it is an input drives its preloaded value in the same cycle that it becomes an output.
- R9: A read of address 0x00 returns the pin levels that `pinIn` held two clock edges earlier, one bit per pin. A level applied after an edge is not yet visible after that first edge alone.
- R10: Writes change state only at 0x04, 0x08, 0x0C and 0x10, and only when address bits 1:0 are 00. A write to 0x00, to any other address or to a misaligned address leaves all state unchanged. Reads of 0x04, of unmapped or misaligned addresses, or with `busSel` low, or with `busWrite` high, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 5 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address and state |
| pinIn | input | 32 | Levels from the pads |
| pinOe | output | 32 | Output enable per pin |
| pinOut | output | 32 | Output value per pin |

## Verification
The bench mixes random direction and masked output writes with directed cases, and compares every result against its own model.

The directed cases cover the following faults:
- An inverted mask, or the two halves swapped, would corrupt pins that were never enabled.
- A latch that cleared when its pin turned to input would break the preloaded-drive case.
- A synchronizer one stage short would show a new level after only one edge.
- An address decode that ignored the low bits, or let a write to the input register through, would change state on a write that must do nothing.

The bench detects each of these faults through `pinOe`, `pinOut` or read-back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;

  typedef struct packed {
    logic              wrSetIn;
    logic              wrSetOut;
    logic [1:0]        wrOut;
    logic [DATA_W-1:0] wdata;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_INPUT,
    RD_DIR,
    RD_OUTLO,
    RD_OUTHI
  } rdsel_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb,
  output rdsel_t            rdSel
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_INPUT  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_SETIN  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_SETOUT = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_OUTLO  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_OUTHI  = IDX_W'(4);

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             doWrite;
  logic             doRead;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign doWrite = busSel && busWrite && aligned;
  assign doRead  = busSel && !busWrite && aligned;

  always_comb begin
    strb          = '0;
    strb.wdata    = busWdata;
    strb.wrSetIn  = doWrite && (wordIdx == IDX_SETIN);
    strb.wrSetOut = doWrite && (wordIdx == IDX_SETOUT);
    strb.wrOut[0] = doWrite && (wordIdx == IDX_OUTLO);
    strb.wrOut[1] = doWrite && (wordIdx == IDX_OUTHI);
  end

  always_comb begin
    rdSel = RD_NONE;
    if (doRead) begin
      unique case (wordIdx)
        IDX_INPUT:  rdSel = RD_INPUT;
        IDX_SETOUT: rdSel = RD_DIR;
        IDX_OUTLO:  rdSel = RD_OUTLO;
        IDX_OUTHI:  rdSel = RD_OUTHI;
        default:    rdSel = RD_NONE;
      endcase
    end
  end

  // R10: at most one write strobe per access
  always_comb begin
    a_one_strobe_r10: assert ($countones({strb.wrSetIn, strb.wrSetOut, strb.wrOut}) <= 1);
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[b] <= '0;
      else       chain[b] <= {chain[b][STAGES-2:0], d[b]};
    end
    assign q[b] = chain[b][STAGES-1];
  end

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= '0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  if (STAGES == 2) begin : g_chk
    p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
      (warm == 2'd3) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rdsel_t            rdSel,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOe,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] dirReg;
  logic [DATA_W-1:0] outLat;
  logic [DATA_W-1:0] inSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dirReg <= '0;
    else if (strb.wrSetOut) dirReg <= dirReg | strb.wdata;
    else if (strb.wrSetIn)  dirReg <= dirReg & ~strb.wdata;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] mask;
    logic [HALF_W-1:0] val;
    assign mask = strb.wdata[DATA_W-1:HALF_W];
    assign val  = strb.wdata[HALF_W-1:0];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        outLat[h*HALF_W +: HALF_W] <= '0;
      else if (strb.wrOut[h])
        outLat[h*HALF_W +: HALF_W] <= (outLat[h*HALF_W +: HALF_W] & ~mask) | (val & mask);
    end

    p_mask_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrOut[h] |=> (((outLat[h*HALF_W +: HALF_W] ^ $past(outLat[h*HALF_W +: HALF_W]))
                          & ~$past(strb.wdata[DATA_W-1:HALF_W])) == '0));
    p_mask_loads_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrOut[h] |=> ((outLat[h*HALF_W +: HALF_W] & $past(strb.wdata[DATA_W-1:HALF_W]))
                         == ($past(strb.wdata[HALF_W-1:0]) & $past(strb.wdata[DATA_W-1:HALF_W]))));
  end

  gpio_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (pinIn),
    .q    (inSync)
  );

  assign pinOe  = dirReg;
  assign pinOut = outLat;

  always_comb begin
    unique case (rdSel)
      RD_INPUT: rdData = inSync;
      RD_DIR:   rdData = dirReg;
      RD_OUTLO: rdData = {{HALF_W{1'b0}}, outLat[HALF_W-1:0]};
      RD_OUTHI: rdData = {{HALF_W{1'b0}}, outLat[DATA_W-1:HALF_W]};
      default:  rdData = '0;
    endcase
  end

  p_setin_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetIn |=> ((pinOe & $past(strb.wdata)) == '0));
  p_setin_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetIn |=> (((pinOe ^ $past(pinOe)) & ~$past(strb.wdata)) == '0));
  p_setout_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetOut |=> ((pinOe & $past(strb.wdata)) == $past(strb.wdata)));
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrSetIn || strb.wrSetOut || (|strb.wrOut)) |=> ($stable(pinOe) && $stable(pinOut)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOe,
  output logic [DATA_W-1:0] pinOut
);
  strobe_t strb;
  rdsel_t  rdSel;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strb     (strb),
    .rdSel    (rdSel)
  );

  gpio_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .pinIn  (pinIn),
    .pinOe  (pinOe),
    .pinOut (pinOut),
    .rdData (busRdata)
  );
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0;
  logic        busWrite = 0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOe;
  logic [31:0] pinOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] mDir;
  logic [31:0] mOut;

  gpio_port dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] fMasked(input logic [31:0] old, input logic [31:0] w, input int half);
    logic [31:0] r = old;
    for (int k = 0; k < 16; k++)
      if (w[16+k]) r[half*16+k] = w[k];
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    rd(5'h08, v); check(req, "dir readback", v, mDir);
    rd(5'h0C, v); check(req, "outlo readback", v, {16'h0, mOut[15:0]});
    rd(5'h10, v); check(req, "outhi readback", v, {16'h0, mOut[31:16]});
    check(req, "pinOe", pinOe, mDir);
    check(req, "pinOut", pinOut, mOut);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unused;
    unused = $urandom(32'h5eed1234);
    mDir = '0; mOut = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1", "pinOe after reset", pinOe, 32'h0);
    check("R1", "pinOut after reset", pinOut, 32'h0);
    checkAll("R1");

    // R3 set outputs, R2 clear some
    wr(5'h08, 32'hF0F0_00FF); mDir |= 32'hF0F0_00FF; checkAll("R3");
    wr(5'h04, 32'h3000_000F); mDir &= ~32'h3000_000F; checkAll("R2");
    wr(5'h08, 32'h0); checkAll("R3 zero write");
    wr(5'h04, 32'h0); checkAll("R2 zero write");

    // R5 / R6 masked writes
    wr(5'h0C, 32'h00FF_FFFF); mOut = fMasked(mOut, 32'h00FF_FFFF, 0); checkAll("R5");
    wr(5'h0C, 32'h0F00_0000); mOut = fMasked(mOut, 32'h0F00_0000, 0); checkAll("R5 clear");
    wr(5'h10, 32'h8001_FFFF); mOut = fMasked(mOut, 32'h8001_FFFF, 1); checkAll("R6");
    wr(5'h10, 32'h0000_0000); checkAll("R6 empty mask");
    rd(5'h0C, v); check("R7", "upper zero lo", v & 32'hFFFF_0000, 32'h0);

    // R8 preload on an input, then switch to output
    wr(5'h04, 32'h0000_0100); mDir &= ~32'h0000_0100;
    wr(5'h0C, 32'h0100_0100); mOut = fMasked(mOut, 32'h0100_0100, 0);
    check("R8", "latch while input", pinOut[8], 1'b1);
    check("R8", "oe still off", pinOe[8], 1'b0);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 5'h08; busWdata = 32'h0000_0100;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0; mDir |= 32'h100;
    check("R8", "drives preloaded at once", {pinOe[8], pinOut[8]}, 32'h3);
    checkAll("R8");

    // R10 ignored writes
    wr(5'h00, 32'hFFFF_FFFF); checkAll("R10 write input reg");
    wr(5'h14, 32'hFFFF_FFFF); checkAll("R10 unmapped");
    wr(5'h09, 32'hFFFF_FFFF); checkAll("R10 misaligned setout");
    wr(5'h0D, 32'hFFFF_FFFF); checkAll("R10 misaligned outlo");
    rd(5'h04, v); check("R10", "setin reads zero", v, 32'h0);
    rd(5'h1C, v); check("R10", "unmapped reads zero", v, 32'h0);
    rd(5'h0A, v); check("R10", "misaligned reads zero", v, 32'h0);
    @(negedge clk); busAddr = 5'h08; busSel = 0; #1;
    check("R10", "no select reads zero", busRdata, 32'h0);

    // R9 input synchronization
    @(negedge clk); pinIn = 32'hA5A5_5A5A;
    @(posedge clk); @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = 5'h00; #1;
    check("R9", "not visible after one edge", busRdata, 32'h0);
    busSel = 0;
    @(posedge clk);
    rd(5'h00, v); check("R9", "visible after two edges", v, 32'hA5A5_5A5A);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] p = $urandom;
      @(negedge clk); pinIn = p;
      @(posedge clk); @(posedge clk);
      rd(5'h00, v); check("R9", "random input", v, p);
    end

    // random mix of R2 R3 R5 R6
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d = $urandom;
      int op = $urandom_range(0, 3);
      case (op)
        0: begin wr(5'h04, d); mDir &= ~d; end
        1: begin wr(5'h08, d); mDir |= d; end
        2: begin wr(5'h0C, d); mOut = fMasked(mOut, d, 0); end
        default: begin wr(5'h10, d); mOut = fMasked(mOut, d, 1); end
      endcase
      if (i % 10 == 0) checkAll("R2 R3 R5 R6 R7 random");
      else begin
        check("R4", "random pinOe", pinOe, mDir);
        check("R8", "random pinOut", pinOut, mOut);
      end
    end
    checkAll("R4 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule